// File: doc/BRIEF.md
# Word Load Alignment and Writeback Unit

This unit carries out one word-load instruction from decoded instruction bits to register writes. When an issue is offered while it is idle, it qualifies the instruction and forms the effective address from a base value and an offset. The condition must have passed and the opcode bits must mark a word load. It then raises a one-cycle word read on a memory port that sees only word-aligned addresses. When the read data comes back, the unit rotates it right by the byte position inside the word. It then drives a destination-register write, an optional base-register writeback, or a branch request when the destination is the program counter.

Condition evaluation, flag logic, register-offset shifting, and byte or halfword loads are done elsewhere. The offset for register mode comes in already shifted. The unit handles one instruction at a time and shows its availability on `ready`.

Top module: `word_load_unit`

## Requirements
- R1: An issue is accepted only when `ready`, `issue` and `cond_ok` are high and the instruction has bits [27:26] = 01, bit 22 = 0 and bit 20 = 1. An accepted issue raises `mem_req` in the following cycle. Any other issue causes no request and no register write, and `ready` stays high.
- R2: An issue with `cond_ok` low changes neither the destination nor the base register. No request is made and no write port or branch output rises.
- R3: The offset is the zero-extended bits [11:0] when bit 25 is 0, and `reg_off` when bit 25 is 1. Bit 23 = 1 adds the offset to the base and bit 23 = 0 subtracts it. Bit 24 = 1 reads at the offset address; bit 24 = 0 reads at the unmodified base.
- R4: `mem_req` is a one-cycle pulse, and `mem_addr` always has bits [1:0] cleared.
- R5: The loaded value is the returned word rotated right by 8 × (low two bits of the read address).
- R6: Register results appear as one-cycle pulses in the cycle after `mem_rvalid` is seen high. `mem_rvalid` is only honoured in the cycles after the request cycle.
- R7: Writeback happens when bit 21 = 1 or bit 24 = 0. The base port then writes the offset address (base ± offset) to register bits [19:16], in the same cycle as the data result.
- R8: When writeback is due and the destination index (bits [15:12]) equals the base index, only the loaded value is written and the base port stays low.
- R9: A destination index of 15 raises `br_req` with `br_target` equal to the loaded value instead of a destination-port write.
- R10: `ready` is low from acceptance until the result cycle. Issues offered while it is low are ignored.
- R11: After reset, `ready` is high and `mem_req`, `rd_we`, `rn_we` and `br_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Offers an instruction this cycle |
| cond_ok | input | 1 | Condition field evaluated true |
| instr | input | 28 | Instruction bits [27:0] |
| base_val | input | 32 | Current value of the base register |
| reg_off | input | 32 | Pre-shifted register offset |
| ready | output | 1 | Idle and able to accept an issue |
| mem_req | output | 1 | Word read request pulse |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 4 | Destination register index |
| rd_val | output | 32 | Rotated loaded value |
| rn_we | output | 1 | Base writeback enable |
| rn_idx | output | 4 | Base register index |
| rn_val | output | 32 | Written-back address |
| br_req | output | 1 | Branch request (load to register 15) |
| br_target | output | 32 | Branch target (loaded value) |

## Verification
The bench tries every byte offset inside a word. A rotation in the wrong direction, or by the wrong amount, shows up as a scrambled destination value, and a design that forgets to clear the low bits shows up as a misaligned request address. It tries add and subtract offsets, immediate and register offsets, and offset-before-access and offset-after-access forms. Swapping the roles of those bits moves the request address or the written-back value. It also aims at the priority of destination over base when both indices match, at the branch path taken instead of a register-15 write, at failed conditions, at non-load encodings, and at issues offered while busy. Each of these would leak a spurious request or write.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int DW       = 32;
    localparam int LANES    = DW / 8;
    localparam int LOFF_W   = $clog2(LANES);
    localparam int RIDX_W   = 4;
    localparam int IMM_W    = 12;
    localparam int INSTR_W  = 28;
    localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(15);

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} lsw_state_e;

    typedef struct packed {
        logic              reg_sel;
        logic              pre;
        logic              up;
        logic              wr_back;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rd;
        logic [IMM_W-1:0]  imm;
    } ld_fields_t;

    typedef struct packed {
        logic [DW-1:0]     acc_addr;
        logic [DW-1:0]     end_addr;
        logic              wb;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rd;
    } ld_ctx_t;

    function automatic logic is_word_load(input logic [INSTR_W-1:0] ins);
        return (ins[27:26] == 2'b01) && !ins[22] && ins[20];
    endfunction

    function automatic ld_fields_t split_fields(input logic [INSTR_W-1:0] ins);
        ld_fields_t f;
        f.reg_sel = ins[25];
        f.pre     = ins[24];
        f.up      = ins[23];
        f.wr_back = ins[21];
        f.rn      = ins[19:16];
        f.rd      = ins[15:12];
        f.imm     = ins[11:0];
        return f;
    endfunction
endpackage

// File: rtl/lsw_addr.sv
module lsw_addr
    import lsw_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [DW-1:0]      base_val,
    input  logic [DW-1:0]      reg_off,
    output logic               is_load,
    output ld_ctx_t            ctx
);
    ld_fields_t    f;
    logic [DW-1:0] off;
    logic [DW-1:0] idx_addr;

    always_comb begin
        f        = split_fields(instr);
        is_load  = is_word_load(instr);
        off      = f.reg_sel ? reg_off : {{(DW-IMM_W){1'b0}}, f.imm};
        idx_addr = f.up ? (base_val + off) : (base_val - off);
        ctx.acc_addr = f.pre ? idx_addr : base_val;
        ctx.end_addr = idx_addr;
        ctx.wb       = f.wr_back || !f.pre;
        ctx.rn       = f.rn;
        ctx.rd       = f.rd;
    end
endmodule

// File: rtl/lsw_rotate.sv
module lsw_rotate
    import lsw_pkg::*;
(
    input  logic [DW-1:0]     din,
    input  logic [LOFF_W-1:0] sel,
    output logic [DW-1:0]     dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LOFF_W-1:0] src;
        assign src = LOFF_W'(i) + sel;
        assign dout[i*8 +: 8] = din[{src, 3'b000} +: 8];
    end
endmodule

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
    import lsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic              cond_ok,
    input  logic              is_load,
    input  ld_ctx_t           ctx_in,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     rot_data,
    output logic [LOFF_W-1:0] rot_sel,
    output logic              ready,
    output logic              mem_req,
    output logic [DW-1:0]     mem_addr,
    output logic              rd_we,
    output logic [RIDX_W-1:0] rd_idx,
    output logic [DW-1:0]     rd_val,
    output logic              rn_we,
    output logic [RIDX_W-1:0] rn_idx,
    output logic [DW-1:0]     rn_val,
    output logic              br_req,
    output logic [DW-1:0]     br_target
);
    lsw_state_e state;
    ld_ctx_t    ctx;

    assign ready    = (state == ST_IDLE);
    assign mem_req  = (state == ST_REQ);
    assign mem_addr = {ctx.acc_addr[DW-1:LOFF_W], {LOFF_W{1'b0}}};
    assign rot_sel  = ctx.acc_addr[LOFF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctx       <= '0;
            rd_we     <= 1'b0;
            rd_idx    <= '0;
            rd_val    <= '0;
            rn_we     <= 1'b0;
            rn_idx    <= '0;
            rn_val    <= '0;
            br_req    <= 1'b0;
            br_target <= '0;
        end else begin
            rd_we  <= 1'b0;
            rn_we  <= 1'b0;
            br_req <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (issue && cond_ok && is_load) begin
                        ctx   <= ctx_in;
                        state <= ST_REQ;
                    end
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        state <= ST_IDLE;
                        if (ctx.rd == PC_IDX) begin
                            br_req    <= 1'b1;
                            br_target <= rot_data;
                        end else begin
                            rd_we  <= 1'b1;
                            rd_idx <= ctx.rd;
                            rd_val <= rot_data;
                        end
                        if (ctx.wb && (ctx.rn != ctx.rd)) begin
                            rn_we  <= 1'b1;
                            rn_idx <= ctx.rn;
                            rn_val <= ctx.end_addr;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/word_load_unit.sv
module word_load_unit
    import lsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               issue,
    input  logic               cond_ok,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DW-1:0]      base_val,
    input  logic [DW-1:0]      reg_off,
    output logic               ready,
    output logic               mem_req,
    output logic [DW-1:0]      mem_addr,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_rvalid,
    output logic               rd_we,
    output logic [RIDX_W-1:0]  rd_idx,
    output logic [DW-1:0]      rd_val,
    output logic               rn_we,
    output logic [RIDX_W-1:0]  rn_idx,
    output logic [DW-1:0]      rn_val,
    output logic               br_req,
    output logic [DW-1:0]      br_target
);
    logic              is_load;
    ld_ctx_t           ctx_in;
    logic [LOFF_W-1:0] rot_sel;
    logic [DW-1:0]     rot_data;

    lsw_addr u_addr (
        .instr    (instr),
        .base_val (base_val),
        .reg_off  (reg_off),
        .is_load  (is_load),
        .ctx      (ctx_in)
    );

    lsw_rotate u_rot (
        .din  (mem_rdata),
        .sel  (rot_sel),
        .dout (rot_data)
    );

    lsw_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .cond_ok    (cond_ok),
        .is_load    (is_load),
        .ctx_in     (ctx_in),
        .mem_rvalid (mem_rvalid),
        .rot_data   (rot_data),
        .rot_sel    (rot_sel),
        .ready      (ready),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .rd_we      (rd_we),
        .rd_idx     (rd_idx),
        .rd_val     (rd_val),
        .rn_we      (rn_we),
        .rn_idx     (rn_idx),
        .rn_val     (rn_val),
        .br_req     (br_req),
        .br_target  (br_target)
    );
endmodule

// File: rtl/word_load_unit_chk.sv
module word_load_unit_chk
    import lsw_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               issue,
    input logic               cond_ok,
    input logic [INSTR_W-1:0] instr,
    input logic               ready,
    input logic               mem_req,
    input logic [DW-1:0]      mem_addr,
    input logic               mem_rvalid,
    input logic               rd_we,
    input logic [RIDX_W-1:0]  rd_idx,
    input logic               rn_we,
    input logic [RIDX_W-1:0]  rn_idx,
    input logic               br_req
);
    AST_ACCEPT_REQ: assert property (@(posedge clk) disable iff (rst)
        (ready && issue && cond_ok && instr[27:26] == 2'b01 && !instr[22] && instr[20]) |=> mem_req); // R1
    AST_COND_FAIL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ready && issue && !cond_ok) |=> (!mem_req && ready)); // R2
    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[LOFF_W-1:0] == '0)); // R4
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R4
    AST_RESULT_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        (rd_we || rn_we || br_req) |-> $past(mem_rvalid)); // R6
    AST_DEST_WINS: assert property (@(posedge clk) disable iff (rst)
        (rd_we && rn_we) |-> (rd_idx != rn_idx)); // R8
    AST_BRANCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        br_req |-> !rd_we); // R9
    AST_BUSY_DURING_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !ready); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (ready && !mem_req && !rd_we && !rn_we && !br_req)); // R11
endmodule

bind word_load_unit word_load_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .cond_ok    (cond_ok),
    .instr      (instr),
    .ready      (ready),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .rd_we      (rd_we),
    .rd_idx     (rd_idx),
    .rn_we      (rn_we),
    .rn_idx     (rn_idx),
    .br_req     (br_req)
);

// File: tb/tb_word_load_unit.sv
module tb_word_load_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic        cond_ok = 1'b0;
    logic [27:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [31:0] reg_off = '0;
    logic        ready, mem_req, rd_we, rn_we, br_req;
    logic [31:0] mem_addr, rd_val, rn_val, br_target;
    logic [31:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic [3:0]  rd_idx, rn_idx;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic        e_rd;
        logic [3:0]  e_rd_idx;
        logic [31:0] e_rd_val;
        logic        e_rn;
        logic [3:0]  e_rn_idx;
        logic [31:0] e_rn_val;
        logic        e_br;
        logic [31:0] e_br_val;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    word_load_unit dut (
        .clk(clk), .rst(rst), .issue(issue), .cond_ok(cond_ok), .instr(instr),
        .base_val(base_val), .reg_off(reg_off), .ready(ready), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_val(rd_val), .rn_we(rn_we),
        .rn_idx(rn_idx), .rn_val(rn_val), .br_req(br_req), .br_target(br_target)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [27:0] mk(input logic i, input logic p, input logic u,
                                       input logic w, input logic [3:0] rn,
                                       input logic [3:0] rd, input logic [11:0] imm);
        return {2'b01, i, p, u, 1'b0, w, 1'b1, rn, rd, imm};
    endfunction

    function automatic logic [31:0] rot(input logic [31:0] d, input logic [1:0] o);
        logic [63:0] t;
        t = {d, d} >> (8 * o);
        return t[31:0];
    endfunction

    // Monitor: pops one expectation per result cycle.
    always @(negedge clk) begin
        if (!rst && (rd_we || rn_we || br_req)) begin
            if (sb.size() == 0) begin
                check("R6 unexpected result", {29'd0, rd_we, rn_we, br_req}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " rd_we"}, {31'd0, rd_we}, {31'd0, e.e_rd});
                if (e.e_rd) begin
                    check({e.tag, " rd_idx"}, {28'd0, rd_idx}, {28'd0, e.e_rd_idx});
                    check({e.tag, " rd_val"}, rd_val, e.e_rd_val);
                end
                check({e.tag, " rn_we"}, {31'd0, rn_we}, {31'd0, e.e_rn});
                if (e.e_rn) begin
                    check({e.tag, " rn_idx"}, {28'd0, rn_idx}, {28'd0, e.e_rn_idx});
                    check({e.tag, " rn_val"}, rn_val, e.e_rn_val);
                end
                check({e.tag, " br_req"}, {31'd0, br_req}, {31'd0, e.e_br});
                if (e.e_br) check({e.tag, " br_target"}, br_target, e.e_br_val);
            end
        end
    end

    // Driver: one full load, including the memory response.
    task automatic do_load(input string tag, input logic [27:0] ins, input logic [31:0] base,
                           input logic [31:0] roff, input logic [31:0] data,
                           input int lat, input bit poke_busy);
        logic [31:0] off, idx, acc;
        logic        wb;
        exp_t        e;
        off = ins[25] ? roff : {20'd0, ins[11:0]};
        idx = ins[23] ? base + off : base - off;
        acc = ins[24] ? idx : base;
        wb  = ins[21] || !ins[24];
        e.tag      = tag;
        e.e_br     = (ins[15:12] == 4'd15);
        e.e_br_val = rot(data, acc[1:0]);
        e.e_rd     = !e.e_br;
        e.e_rd_idx = ins[15:12];
        e.e_rd_val = rot(data, acc[1:0]);
        e.e_rn     = wb && (ins[19:16] != ins[15:12]);
        e.e_rn_idx = ins[19:16];
        e.e_rn_val = idx;
        sb.push_back(e);
        @(negedge clk);
        issue = 1'b1; cond_ok = 1'b1; instr = ins; base_val = base; reg_off = roff;
        @(negedge clk);
        issue = 1'b0;
        check({tag, " R4 mem_req"}, {31'd0, mem_req}, 32'd1);
        check({tag, " R3 R4 mem_addr"}, mem_addr, {acc[31:2], 2'b00});
        check({tag, " R10 ready low"}, {31'd0, ready}, 32'd0);
        if (poke_busy) begin
            issue = 1'b1; instr = mk(0, 1, 1, 0, 4'd1, 4'd2, 12'h040);
        end
        @(negedge clk);
        issue = 1'b0;
        check({tag, " R4 single pulse"}, {31'd0, mem_req}, 32'd0);
        repeat (lat) @(negedge clk);
        mem_rdata = data; mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        @(negedge clk);
        check({tag, " R6 result seen"}, sb.size(), 32'd0);
        check({tag, " R10 no extra request"}, {31'd0, mem_req}, 32'd0);
        check({tag, " R10 ready again"}, {31'd0, ready}, 32'd1);
    endtask

    // Issue that must be ignored: no request, ready stays high, no result.
    task automatic do_ignored(input string tag, input logic [27:0] ins, input logic c);
        @(negedge clk);
        issue = 1'b1; cond_ok = c; instr = ins; base_val = 32'h0000_4000;
        @(negedge clk);
        issue = 1'b0;
        check({tag, " no mem_req"}, {31'd0, mem_req}, 32'd0);
        check({tag, " ready held"}, {31'd0, ready}, 32'd1);
        repeat (3) @(negedge clk);
        check({tag, " still no mem_req"}, {31'd0, mem_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset ready", {31'd0, ready}, 32'd1);
        check("R11 reset mem_req", {31'd0, mem_req}, 32'd0);
        check("R11 reset outputs", {29'd0, rd_we, rn_we, br_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        do_load("R3 R5 aligned imm add",      mk(0, 1, 1, 0, 4'd2, 4'd1, 12'h010), 32'h0000_1000, 0, 32'hA1B2_C3D4, 0, 0);
        do_load("R5 offset1 rotate8",         mk(0, 1, 1, 0, 4'd2, 4'd1, 12'h001), 32'h0000_1000, 0, 32'h1122_3344, 1, 0);
        do_load("R3 R5 R7 subtract offset2 wb", mk(0, 1, 0, 1, 4'd3, 4'd4, 12'h006), 32'h0000_2000, 0, 32'h5566_7788, 2, 0);
        do_load("R3 R5 reg offset offset3",   mk(1, 1, 1, 0, 4'd5, 4'd6, 12'hFFF), 32'h0000_0100, 32'h7, 32'hDEAD_BEEF, 0, 0);
        do_load("R3 R7 post-index",           mk(0, 0, 1, 0, 4'd7, 4'd8, 12'h020), 32'h0000_3002, 0, 32'hCAFE_F00D, 3, 0);
        do_load("R7 post-index subtract reg", mk(1, 0, 0, 0, 4'd9, 4'd10, 12'h000), 32'h0000_3003, 32'h40, 32'h0102_0304, 1, 0);
        do_load("R8 rd equals rn wb",         mk(0, 1, 1, 1, 4'd11, 4'd11, 12'h004), 32'h0000_5000, 0, 32'h9999_AAAA, 0, 0);
        do_load("R9 load to pc",              mk(0, 1, 1, 0, 4'd12, 4'd15, 12'h002), 32'h0000_6000, 0, 32'h0000_8800, 1, 0);
        do_load("R9 R7 pc with wb",           mk(0, 1, 0, 1, 4'd13, 4'd15, 12'h008), 32'h0000_6010, 0, 32'h0000_9000, 0, 0);
        do_load("R10 issue while busy",       mk(0, 1, 1, 0, 4'd1, 4'd2, 12'h000), 32'h0000_7000, 0, 32'h7777_0000, 2, 1);

        do_ignored("R2 cond fail",               mk(0, 1, 1, 1, 4'd1, 4'd2, 12'h004), 1'b0);
        do_ignored("R1 store encoding",          mk(0, 1, 1, 0, 4'd1, 4'd2, 12'h004) & ~28'h010_0000, 1'b1);
        do_ignored("R1 byte encoding",           mk(0, 1, 1, 0, 4'd1, 4'd2, 12'h004) | 28'h040_0000, 1'b1);
        do_ignored("R1 wrong class bits",        mk(0, 1, 1, 0, 4'd1, 4'd2, 12'h004) ^ 28'hC00_0000, 1'b1);

        check("R1 R2 no stray results", sb.size(), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule